// File: doc/BRIEF.md
# HDLC Receive Deframer

This block sits behind a bit-level demodulator. It takes recovered line bits, one per cycle when `bit_valid` is high, and turns them into a byte stream. It finds opening and closing flags, drops frames on an abort pattern, and strips the zero bits that the sender inserted after runs of ones. Bytes are built least significant bit first.

Framing is reported inside the byte stream itself. Every flag that is seen comes out as the byte 0x7E. A payload byte whose value matches one of the three reserved codes (0x7E, 0x7F or 0x1B) is sent with 0x1B in front of it. A downstream consumer can therefore split frames without any sideband signal.

The output is a small buffer with a valid/ready handshake. The input has no backpressure. If the buffer cannot take what a bit produces, that output is thrown away. The block then stops receiving and waits for the next flag.

Top module: `hdlc_rx_deframer`

## Requirements
- R1: After reset `out_valid` is low, and the block is not receiving, so no payload byte appears before a flag has been seen.
- R2: When the last eight accepted bits, newest in bit 0, equal 0x7E, the block does three things. It emits the byte 0x7E, enters the receiving state and restarts byte assembly.
- R3: When the last seven accepted bits are all ones, the block leaves the receiving state. It emits nothing until a later flag is seen.
- R4: Outside the receiving state, every bit is ignored except for flag detection, and no byte is emitted.
- R5: While receiving, a zero bit that directly follows five consecutive ones is dropped and does not count as a data bit.
- R6: Data bits are packed least significant bit first. The first data bit after a flag becomes bit 0 of the first byte, and each eight data bits make one output byte.
- R7: A completed byte equal to 0x7E, 0x7F or 0x1B is output as the escape byte 0x1B followed directly by the byte itself. Any other byte is output alone.
- R8: When a completed byte needs more free buffer slots than are available, the byte is discarded and receiving stops until the next flag. A plain byte needs one slot; an escaped byte needs two.
- R9: When a flag is seen and the buffer has no free slot, no 0x7E is emitted and the block leaves the receiving state.
- R10: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` holds its value.

Flag checking takes priority over abort checking, and abort checking takes priority over stuffed-bit removal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_valid | input | 1 | A decoded line bit is present this cycle |
| bit_in | input | 1 | Decoded line bit value |
| out_valid | output | 1 | `out_data` holds a byte |
| out_data | output | 8 | Next byte of the output stream |
| out_ready | input | 1 | Consumer accepts `out_data` this cycle |

## Verification
The bench uses the default buffer depth of two. With that depth, an escape pair fills the buffer exactly. A single flag followed by an escaped byte, or two pending bytes followed by one more, is then enough to reach both overflow paths, and also the case of a flag arriving at a full buffer. Stuffing is exercised with all-ones and near-flag payloads, including a run of ones that crosses into the closing flag.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;
  localparam int unsigned BYTE_W = 8;

  localparam logic [BYTE_W-1:0] FLAG_CODE  = 8'h7E;
  localparam logic [BYTE_W-1:0] ABORT_CODE = 8'h7F;
  localparam logic [BYTE_W-1:0] ESC_CODE   = 8'h1B;

  // true for payload values that must be preceded by the escape byte
  function automatic logic is_reserved(input logic [BYTE_W-1:0] b);
    return (b == FLAG_CODE) || (b == ABORT_CODE) || (b == ESC_CODE);
  endfunction
endpackage

// File: rtl/hdlc_rx_history.sv
module hdlc_rx_history
  import hdlc_rx_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic shift_en,
  input  logic bit_in,
  output logic is_flag,
  output logic is_abort,
  output logic is_stuff
);
  logic [BYTE_W-1:0] hist_q;
  logic [BYTE_W-1:0] hist_nxt;

  assign hist_nxt = {hist_q[BYTE_W-2:0], bit_in};

  // pattern decode on the history including the incoming bit
  assign is_flag  = (hist_nxt == FLAG_CODE);
  assign is_abort = &hist_nxt[6:0];
  assign is_stuff = (hist_nxt[5:0] == 6'b111110);

  always_ff @(posedge clk) begin
    if (rst)           hist_q <= '0;
    else if (shift_en) hist_q <= hist_nxt;
  end
endmodule

// File: rtl/hdlc_rx_out_fifo.sv
module hdlc_rx_out_fifo
  import hdlc_rx_pkg::*;
#(
  parameter int unsigned DEPTH = 2,
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        push_cnt,
  input  logic [BYTE_W-1:0] push_b0,
  input  logic [BYTE_W-1:0] push_b1,
  input  logic              pop,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_data,
  output logic [CW-1:0]     fill
);
  logic [BYTE_W-1:0] mem [DEPTH];
  logic [PW-1:0]     wr_q, rd_q;
  logic [CW-1:0]     cnt_q;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // storage without reset so it can map onto RAM
  always_ff @(posedge clk) begin
    if (push_cnt != 2'd0) mem[wr_q] <= push_b0;
    if (push_cnt == 2'd2) mem[ptr_inc(wr_q)] <= push_b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      case (push_cnt)
        2'd1:    wr_q <= ptr_inc(wr_q);
        2'd2:    wr_q <= ptr_inc(ptr_inc(wr_q));
        default: wr_q <= wr_q;
      endcase
      if (pop) rd_q <= ptr_inc(rd_q);
      cnt_q <= cnt_q + CW'(push_cnt) - CW'(pop);
    end
  end

  assign out_valid = (cnt_q != '0);
  assign out_data  = mem[rd_q];
  assign fill      = cnt_q;
endmodule

// File: rtl/hdlc_rx_deframer.sv
module hdlc_rx_deframer
  import hdlc_rx_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_valid,
  input  logic              bit_in,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_data,
  input  logic              out_ready
);
  localparam int unsigned CW = $clog2(FIFO_DEPTH + 1);
  localparam int unsigned BCW = $clog2(BYTE_W);

  logic is_flag, is_abort, is_stuff;
  logic rx_on, rx_n;
  logic [BYTE_W-1:0] acc_q, acc_n, byte_w;
  logic [BCW-1:0] bcnt_q, bcnt_n;
  logic [1:0] push_cnt;
  logic [BYTE_W-1:0] push_b0, push_b1;
  logic [CW-1:0] fifo_fill, free_slots;

  hdlc_rx_history u_hist (
    .clk     (clk),
    .rst     (rst),
    .shift_en(bit_valid),
    .bit_in  (bit_in),
    .is_flag (is_flag),
    .is_abort(is_abort),
    .is_stuff(is_stuff)
  );

  hdlc_rx_out_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk      (clk),
    .rst      (rst),
    .push_cnt (push_cnt),
    .push_b0  (push_b0),
    .push_b1  (push_b1),
    .pop      (out_valid && out_ready),
    .out_valid(out_valid),
    .out_data (out_data),
    .fill     (fifo_fill)
  );

  // free space ignores a pop in the same cycle, so a push never overruns
  assign free_slots = CW'(FIFO_DEPTH) - fifo_fill;
  assign byte_w     = {bit_in, acc_q[BYTE_W-1:1]};

  always_comb begin
    rx_n     = rx_on;
    acc_n    = acc_q;
    bcnt_n   = bcnt_q;
    push_cnt = 2'd0;
    push_b0  = FLAG_CODE;
    push_b1  = byte_w;
    if (bit_valid) begin
      if (is_flag) begin
        acc_n  = '0;
        bcnt_n = '0;
        if (free_slots >= CW'(1)) begin
          push_cnt = 2'd1;
          rx_n     = 1'b1;
        end else begin
          rx_n = 1'b0;
        end
      end else if (is_abort) begin
        rx_n = 1'b0;
      end else if (rx_on && !is_stuff) begin
        if (bcnt_q == BCW'(BYTE_W - 1)) begin
          acc_n  = '0;
          bcnt_n = '0;
          if (is_reserved(byte_w)) begin
            if (free_slots >= CW'(2)) begin
              push_cnt = 2'd2;
              push_b0  = ESC_CODE;
            end else begin
              rx_n = 1'b0;
            end
          end else if (free_slots >= CW'(1)) begin
            push_cnt = 2'd1;
            push_b0  = byte_w;
          end else begin
            rx_n = 1'b0;
          end
        end else begin
          acc_n  = byte_w;
          bcnt_n = bcnt_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_on  <= 1'b0;
      acc_q  <= '0;
      bcnt_q <= '0;
    end else begin
      rx_on  <= rx_n;
      acc_q  <= acc_n;
      bcnt_q <= bcnt_n;
    end
  end
endmodule

// File: rtl/hdlc_rx_deframer_chk.sv
module hdlc_rx_deframer_chk
  import hdlc_rx_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 2,
  localparam int unsigned CW = $clog2(FIFO_DEPTH + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              bit_valid,
  input logic              bit_in,
  input logic              out_valid,
  input logic [BYTE_W-1:0] out_data,
  input logic              out_ready,
  input logic              rx_on,
  input logic [CW-1:0]     fill
);
  logic [6:0] seen_q;
  logic       esc_pend_q;
  logic [7:0] seen_nxt;

  assign seen_nxt = {seen_q, bit_in};

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q     <= '0;
      esc_pend_q <= 1'b0;
    end else begin
      if (bit_valid) seen_q <= seen_nxt[6:0];
      if (out_valid && out_ready)
        esc_pend_q <= !esc_pend_q && (out_data == ESC_CODE);
    end
  end

  // R1
  a_r1_reset_empty: assert property (@(posedge clk) rst |=> !out_valid);

  // R3
  a_r3_abort_leaves_rx: assert property (@(posedge clk) disable iff (rst)
    (bit_valid && seen_nxt[6:0] == 7'h7F) |=> !rx_on);

  // R4
  a_r4_idle_no_push: assert property (@(posedge clk) disable iff (rst)
    (!rx_on && !(bit_valid && seen_nxt == FLAG_CODE)) |=> fill <= $past(fill));

  // R7
  a_r7_escape_pair: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && out_data == ESC_CODE && !esc_pend_q) |=>
      (out_valid && is_reserved(out_data)));

  // R10
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R8
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (rst)
    fill <= CW'(FIFO_DEPTH));
endmodule

bind hdlc_rx_deframer hdlc_rx_deframer_chk #(.FIFO_DEPTH(FIFO_DEPTH)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .bit_valid(bit_valid),
  .bit_in   (bit_in),
  .out_valid(out_valid),
  .out_data (out_data),
  .out_ready(out_ready),
  .rx_on    (rx_on),
  .fill     (fifo_fill)
);

// File: tb/hdlc_rx_deframer_test.sv
`timescale 1ns/1ps
module hdlc_rx_deframer_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_valid = 1'b0;
  logic bit_in = 1'b0;
  logic out_ready = 1'b1;
  logic out_valid;
  logic [7:0] out_data;

  int checks = 0;
  int fails = 0;
  int ones_run = 0;
  logic [7:0] cap [256];
  logic [7:0] expq [256];
  int ncap = 0;
  int nexp = 0;

  always #2.5 clk = ~clk;

  hdlc_rx_deframer #(.FIFO_DEPTH(2)) uut (
    .clk(clk), .rst(rst), .bit_valid(bit_valid), .bit_in(bit_in),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready)
  );

  // capture accepted bytes, sampled 1 ns after the falling edge
  always @(negedge clk) begin
    #1;
    if (!rst && out_valid && out_ready && ncap < 256) begin
      cap[ncap] = out_data;
      ncap++;
    end
  end

  // {reserved, byte}: framed alone between two flags
  localparam logic [8:0] VEC [8] = '{
    9'h001, 9'h080, 9'h0A5, 9'h17E, 9'h17F, 9'h11B, 9'h0FF, 9'h03E
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    bit_valid = 1'b1;
    bit_in = b;
    @(negedge clk);
    bit_valid = 1'b0;
  endtask

  task automatic send_flag();
    for (int i = 0; i < 8; i++) send_bit(((8'h7E >> i) & 1) != 0);
    ones_run = 0;
  endtask

  task automatic send_abort();
    for (int i = 0; i < 8; i++) send_bit(1'b1);
    ones_run = 0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      send_bit(b[i]);
      if (b[i]) ones_run++; else ones_run = 0;
      if (ones_run == 5) begin
        send_bit(1'b0);
        ones_run = 0;
      end
    end
  endtask

  task automatic expect_b(input logic [7:0] b);
    expq[nexp] = b;
    nexp++;
  endtask

  task automatic start_test();
    ncap = 0;
    nexp = 0;
  endtask

  task automatic finish_test(input string tag);
    repeat (12) @(negedge clk);
    chk(ncap == nexp, {tag, " byte count"}, ncap, nexp);
    for (int i = 0; i < nexp; i++)
      chk(i < ncap && cap[i] == expq[i], tag, cap[i], expq[i]);
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk(out_valid == 1'b0, "R1 reset out_valid", out_valid, 0);

    // R4: no flag yet, bytes ignored
    start_test();
    send_byte(8'h55); send_byte(8'h12); send_byte(8'h55);
    finish_test("R4 pre-flag ignored");

    // R2 R5 R6 R7: table of single-byte frames
    for (int v = 0; v < 8; v++) begin
      start_test();
      send_flag();
      send_byte(VEC[v][7:0]);
      send_flag();
      expect_b(8'h7E);
      if (VEC[v][8]) expect_b(8'h1B);
      expect_b(VEC[v][7:0]);
      expect_b(8'h7E);
      finish_test("R2/R5/R6/R7 vector");
    end

    // R6: multi-byte order
    start_test();
    send_flag(); send_byte(8'h12); send_byte(8'h34); send_byte(8'hC3); send_flag();
    expect_b(8'h7E); expect_b(8'h12); expect_b(8'h34); expect_b(8'hC3); expect_b(8'h7E);
    finish_test("R6 byte order");

    // R3: abort, then bytes ignored until flag
    start_test();
    send_flag(); send_byte(8'h21); send_abort(); send_byte(8'h44); send_byte(8'h45);
    send_flag(); send_byte(8'h46); send_flag();
    expect_b(8'h7E); expect_b(8'h21); expect_b(8'h7E); expect_b(8'h46); expect_b(8'h7E);
    finish_test("R3 abort");

    // R8 R10: escaped byte needs two slots, only one free
    start_test();
    out_ready = 1'b0;
    send_flag(); send_byte(8'h1B); send_byte(8'h30);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(out_valid == 1'b1 && out_data == 8'h7E, "R10 hold while stalled", out_data, 8'h7E);
    end
    out_ready = 1'b1;
    send_byte(8'h30);
    expect_b(8'h7E);
    finish_test("R8 escaped overflow");
    start_test();
    send_flag(); send_byte(8'h31); send_flag();
    expect_b(8'h7E); expect_b(8'h31); expect_b(8'h7E);
    finish_test("R8 resync after overflow");

    // R8: plain byte with no slot left
    start_test();
    out_ready = 1'b0;
    send_flag(); send_byte(8'h40); send_byte(8'h41);
    out_ready = 1'b1;
    send_byte(8'h42);
    expect_b(8'h7E); expect_b(8'h40);
    finish_test("R8 plain overflow");

    // R9: flag with full buffer
    start_test();
    out_ready = 1'b0;
    send_flag(); send_flag(); send_flag(); send_byte(8'h32);
    out_ready = 1'b1;
    send_byte(8'h33);
    expect_b(8'h7E); expect_b(8'h7E);
    finish_test("R9 flag when full");
    start_test();
    send_flag(); send_byte(8'h34); send_flag();
    expect_b(8'h7E); expect_b(8'h34); expect_b(8'h7E);
    finish_test("R9 resync");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule